// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer clocked directly by a slow 32 kHz clock. A prescaler turns the clock into timeout units of `TICK_DIV` periods. With the default of 512, 64 units make one second. An 11-bit down counter runs in these units. Software configures the block through a plain 32-bit register port with a write strobe and a word address. Reads are combinational.

Every write to the mode, length, restart and software-reset registers must carry its own key, or the write is dropped. When the counter runs out, the block can raise an interrupt, pulse a system reset, or escalate from the interrupt to the reset on a second expiry. The reset pulse can also be driven onto an external pin whose active level is programmable.

A status register records which kind of reset occurred. A boot-stage register survives every reset except power-on, so firmware can leave markers across a watchdog reboot.

Top module: `keyed_wdt`

## Requirements
- R1: Length register (word address 1) holds the timeout in bits 15:5. A write takes effect only if bits 4:0 equal 0x08. It reads back the timeout in bits 15:5 with other bits zero, and its power-on value reads 0x0000FFE0.
- R2: Mode register (word address 0) accepts a write only if bits 31:24 equal 0x22. Bit 0 is enable, bit 1 is external polarity, bit 2 is external enable, bit 3 is interrupt select, bit 4 is a software flag and bit 6 is dual mode. Reads return those bits, with other bits zero. A wrong key changes nothing.
- R3: While enabled, expiry happens exactly timeout × `TICK_DIV` clock cycles after the enabling mode write or the last accepted restart.
- R4: A write to word address 2 whose bits 15:0 equal 0x1971 reloads the counter, restarts the prescaler and clears a pending interrupt. Any other value is ignored.
- R5: With interrupt select set and dual mode clear, expiry sets `irq`, which stays high until a restart or a reset event. The counter reloads and no reset is produced.
- R6: With interrupt select and dual mode both clear, expiry drives `sysRst` high for `PULSE_LEN` cycles starting the cycle after expiry. It also sets status bit 31, clears the mode register and clears `irq`.
- R7: In dual mode, the first expiry raises `irq` and reloads the counter. A second expiry with no restart in between produces the reset of R6.
- R8: A write to word address 5 with bits 15:0 equal 0x1209 starts the reset pulse in the next cycle whatever the counter holds, and sets status bit 30. Any other value is ignored.
- R9: `extRst` carries the reset pulse at the level of the polarity bit sampled at the reset event, but only if external enable was set then. Otherwise it rests at the inverse of the current polarity bit, so it idles high after power-on.
- R10: Boot-stage register (word address 4) holds 11 bits and writes need no key. It powers on as 0x7FF, and watchdog and software resets leave it unchanged.
- R11: Status (word address 3) bits 31 and 30 are sticky and clear only on power-on reset.
- R12: An accepted restart in the cycle of an expiry wins, so no expiry happens. A software reset in the cycle of a watchdog reset wins, so only status bit 30 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32 kHz timer and register clock |
| porRst_n | input | 1 | Asynchronous power-on reset, active low |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wrData | input | 32 | Write data including key |
| rdData | output | 32 | Combinational read data for `addr` |
| irq | output | 1 | Watchdog interrupt, level |
| sysRst | output | 1 | System reset pulse, active high |
| extRst | output | 1 | External reset pin, programmable polarity |

## Verification
Two events can land on the same edge. The first is a keyed restart and a counter expiry. The bench enables the timer, counts the exact number of cycles to expiry, and times the restart write so that its edge is the expiry edge. It then requires `irq` to stay low and the next expiry to arrive one full period later. The second is a software reset and a watchdog reset. After a fresh power-on, the software-reset write is timed to the expiry edge, and the status register must show only the software-reset bit.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_MODE  = 3'd0;
  localparam logic [ADDR_W-1:0] A_LEN   = 3'd1;
  localparam logic [ADDR_W-1:0] A_KICK  = 3'd2;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd3;
  localparam logic [ADDR_W-1:0] A_IVAL  = 3'd4;
  localparam logic [ADDR_W-1:0] A_SWRST = 3'd5;

  localparam logic [7:0]  MODE_KEY  = 8'h22;
  localparam logic [4:0]  LEN_KEY   = 5'h08;
  localparam logic [15:0] KICK_KEY  = 16'h1971;
  localparam logic [15:0] SWRST_KEY = 16'h1209;

  typedef struct packed {
    logic dual;
    logic flag;
    logic irqSel;
    logic extEn;
    logic extPol;
    logic en;
  } mode_t;

  // control -> datapath strobes
  typedef struct packed {
    logic kick;
    logic swReset;
  } strobe_t;

  // datapath -> control events
  typedef struct packed {
    logic wdtRst;
    logic anyRst;
  } event_t;
endpackage

// File: rtl/keyed_wdt_ctrl.sv
module keyed_wdt_ctrl
  import keyed_wdt_pkg::*;
#(
  parameter int TO_W = 11,
  parameter int IVAL_W = 11,
  parameter logic [TO_W-1:0] DEF_TIMEOUT = '1
) (
  input  logic              clk,
  input  logic              porRst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output mode_t             modeQ,
  output logic [TO_W-1:0]   timeoutQ,
  output strobe_t           strobe,
  input  event_t            evt,
  output logic [1:0]        statQ,
  output logic [IVAL_W-1:0] ivalQ
);
  localparam int TO_LSB = 5;

  logic modeWr, lenWr, ivalWr;
  logic unusedHi;

  assign modeWr = wrEn && addr == A_MODE && wrData[31:24] == MODE_KEY;
  assign lenWr  = wrEn && addr == A_LEN && wrData[4:0] == LEN_KEY;
  assign ivalWr = wrEn && addr == A_IVAL;
  assign strobe.kick    = wrEn && addr == A_KICK && wrData[15:0] == KICK_KEY;
  assign strobe.swReset = wrEn && addr == A_SWRST && wrData[15:0] == SWRST_KEY;
  assign unusedHi = ^wrData[23:16];

  always_ff @(posedge clk or negedge porRst_n) begin
    if (!porRst_n) begin
      modeQ    <= '0;
      timeoutQ <= DEF_TIMEOUT;
      statQ    <= '0;
      ivalQ    <= '1;
    end else begin
      if (evt.anyRst)
        modeQ <= '0;
      else if (modeWr)
        modeQ <= '{dual: wrData[6], flag: wrData[4], irqSel: wrData[3],
                   extEn: wrData[2], extPol: wrData[1], en: wrData[0]};
      if (lenWr)  timeoutQ <= wrData[TO_LSB +: TO_W];
      if (ivalWr) ivalQ <= wrData[IVAL_W-1:0];
      if (evt.wdtRst)     statQ[1] <= 1'b1;
      if (strobe.swReset) statQ[0] <= 1'b1;
    end
  end

  always_comb begin
    rdData = '0;
    case (addr)
      A_MODE: rdData[6:0] = {modeQ.dual, 1'b0, modeQ.flag, modeQ.irqSel,
                             modeQ.extEn, modeQ.extPol, modeQ.en};
      A_LEN:  rdData[TO_LSB +: TO_W] = timeoutQ;
      A_STAT: rdData[31:30] = statQ;
      A_IVAL: rdData[IVAL_W-1:0] = ivalQ;
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/keyed_wdt_dp.sv
module keyed_wdt_dp
  import keyed_wdt_pkg::*;
#(
  parameter int TO_W = 11,
  parameter int TICK_DIV = 512,
  parameter int PULSE_LEN = 16
) (
  input  logic            clk,
  input  logic            porRst_n,
  input  mode_t           modeQ,
  input  logic [TO_W-1:0] timeoutQ,
  input  strobe_t         strobe,
  output event_t          evt,
  output logic            irq,
  output logic            sysRst,
  output logic            extRst
);
  localparam int PRE_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam int PL_W  = $clog2(PULSE_LEN + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  logic [PRE_W-1:0] preCnt;
  logic [TO_W-1:0]  cnt;
  logic [PL_W-1:0]  pulseCnt;
  logic irqQ, polL, extEnL;
  logic tick, expire, armed, hold;

  always_comb begin
    tick   = modeQ.en && preCnt == PRE_LAST;
    expire = tick && cnt <= TO_W'(1) && !strobe.kick;
    armed  = modeQ.dual ? irqQ : !modeQ.irqSel;
    evt.wdtRst = expire && armed && !strobe.swReset;
    evt.anyRst = evt.wdtRst || strobe.swReset;
    hold   = !modeQ.en || strobe.kick || evt.anyRst;
  end

  always_ff @(posedge clk or negedge porRst_n) begin
    if (!porRst_n) begin
      preCnt   <= '0;
      cnt      <= '0;
      irqQ     <= 1'b0;
      pulseCnt <= '0;
      polL     <= 1'b0;
      extEnL   <= 1'b0;
    end else begin
      if (hold || tick) preCnt <= '0;
      else              preCnt <= preCnt + 1'b1;

      if (hold)      cnt <= timeoutQ;
      else if (tick) cnt <= (cnt <= TO_W'(1)) ? timeoutQ : cnt - 1'b1;

      if (strobe.kick || evt.anyRst)             irqQ <= 1'b0;
      else if (expire && (modeQ.irqSel || modeQ.dual)) irqQ <= 1'b1;

      if (evt.anyRst) begin
        pulseCnt <= PL_W'(PULSE_LEN);
        polL     <= modeQ.extPol;
        extEnL   <= modeQ.extEn;
      end else if (pulseCnt != '0) begin
        pulseCnt <= pulseCnt - 1'b1;
      end
    end
  end

  assign irq    = irqQ;
  assign sysRst = pulseCnt != '0;
  assign extRst = (sysRst && extEnL) ? polL : ~modeQ.extPol;
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import keyed_wdt_pkg::*;
#(
  parameter int TICK_DIV = 512,
  parameter int PULSE_LEN = 16,
  parameter logic [10:0] DEF_TIMEOUT = 11'h7FF
) (
  input  logic        clk,
  input  logic        porRst_n,
  input  logic        wrEn,
  input  logic [2:0]  addr,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        irq,
  output logic        sysRst,
  output logic        extRst
);
  localparam int TO_W = 11;
  localparam int IVAL_W = 11;

  mode_t             modeQ;
  logic [TO_W-1:0]   timeoutQ;
  strobe_t           strobe;
  event_t            evt;
  logic [1:0]        statQ;
  logic [IVAL_W-1:0] ivalQ;

  keyed_wdt_ctrl #(.TO_W(TO_W), .IVAL_W(IVAL_W), .DEF_TIMEOUT(DEF_TIMEOUT)) u_ctrl (
    .clk(clk), .porRst_n(porRst_n), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .modeQ(modeQ), .timeoutQ(timeoutQ), .strobe(strobe),
    .evt(evt), .statQ(statQ), .ivalQ(ivalQ)
  );

  keyed_wdt_dp #(.TO_W(TO_W), .TICK_DIV(TICK_DIV), .PULSE_LEN(PULSE_LEN)) u_dp (
    .clk(clk), .porRst_n(porRst_n), .modeQ(modeQ), .timeoutQ(timeoutQ),
    .strobe(strobe), .evt(evt), .irq(irq), .sysRst(sysRst), .extRst(extRst)
  );
endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk
  import keyed_wdt_pkg::*;
#(
  parameter int IVAL_W = 11
) (
  input logic              clk,
  input logic              porRst_n,
  input logic              wrEn,
  input logic [2:0]        addr,
  input logic [15:0]       wrKey,
  input logic              irq,
  input logic              sysRst,
  input logic [1:0]        statQ,
  input logic [IVAL_W-1:0] ivalQ
);
  logic kickWr, swWr, ivalWr;
  assign kickWr = wrEn && addr == A_KICK && wrKey == KICK_KEY;
  assign swWr   = wrEn && addr == A_SWRST && wrKey == SWRST_KEY;
  assign ivalWr = wrEn && addr == A_IVAL;

  AST_SWRST_NEXT: assert property (@(posedge clk) disable iff (!porRst_n) swWr |=> sysRst); // R8
  AST_KICK_CLR_IRQ: assert property (@(posedge clk) disable iff (!porRst_n) kickWr |=> !irq); // R4
  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!porRst_n) (irq && !kickWr) |=> (irq || sysRst)); // R5
  AST_RST_CLR_IRQ: assert property (@(posedge clk) disable iff (!porRst_n) $rose(sysRst) |-> !irq); // R6
  AST_WDT_STICKY: assert property (@(posedge clk) disable iff (!porRst_n) statQ[1] |=> statQ[1]); // R11
  AST_SW_STICKY: assert property (@(posedge clk) disable iff (!porRst_n) statQ[0] |=> statQ[0]); // R11
  AST_IVAL_HOLD: assert property (@(posedge clk) disable iff (!porRst_n) !ivalWr |=> $stable(ivalQ)); // R10
endmodule

bind keyed_wdt keyed_wdt_chk #(.IVAL_W(11)) u_chk (
  .clk(clk), .porRst_n(porRst_n), .wrEn(wrEn), .addr(addr), .wrKey(wrData[15:0]),
  .irq(irq), .sysRst(sysRst), .statQ(statQ), .ivalQ(ivalQ)
);

// File: tb/keyed_wdt_tb.sv
module keyed_wdt_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV = 4;
  localparam int PLEN = 6;
  localparam int L = 3;
  localparam int PER = L * TDIV;

  localparam logic [2:0] M_MODE = 3'd0, M_LEN = 3'd1, M_KICK = 3'd2,
                         M_STAT = 3'd3, M_IVAL = 3'd4, M_SW = 3'd5;

  typedef struct packed {
    logic [2:0]  wa;
    logic [31:0] wd;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{M_MODE, 32'h2100_0045, 32'h0000_0000},
    '{M_MODE, 32'h2200_0056, 32'h0000_0056},
    '{M_LEN,  32'h0000_00A7, 32'h0000_FFE0},
    '{M_LEN,  32'h0000_0068, 32'h0000_0060},
    '{M_IVAL, 32'h0000_0ABC, 32'h0000_02BC},
    '{M_MODE, 32'h2200_0000, 32'h0000_0000},
    '{M_LEN,  32'h0000_0064, 32'h0000_0060}
  };

  logic clk = 1'b0;
  logic porRst_n = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic irq, sysRst, extRst;
  int errs = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyed_wdt #(.TICK_DIV(TDIV), .PULSE_LEN(PLEN)) u_dut (
    .clk(clk), .porRst_n(porRst_n), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .irq(irq), .sysRst(sysRst), .extRst(extRst)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdData;
  endtask

  function automatic string tagOf(input logic [2:0] a);
    if (a == M_MODE) return "R2";
    if (a == M_LEN)  return "R1";
    return "R10";
  endfunction

  task automatic por();
    porRst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    porRst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errs++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    por();
    // reset state
    chk("R5 irq after reset", {31'b0, irq}, 32'd0);
    chk("R6 sysRst after reset", {31'b0, sysRst}, 32'd0);
    chk("R9 extRst idle", {31'b0, extRst}, 32'd1);
    rd(M_MODE, v); chk("R2 mode reset", v, 32'h0);
    rd(M_LEN, v);  chk("R1 length reset", v, 32'h0000_FFE0);
    rd(M_STAT, v); chk("R11 status reset", v, 32'h0);
    rd(M_IVAL, v); chk("R10 interval reset", v, 32'h0000_07FF);

    // register/key table
    for (int i = 0; i < NV; i++) begin
      wr(VECS[i].wa, VECS[i].wd);
      rd(VECS[i].wa, v);
      chk(tagOf(VECS[i].wa), v, VECS[i].exp);
    end

    // interrupt mode timing
    @(negedge clk);
    wr(M_MODE, 32'h2200_0009);
    repeat (PER - 1) @(posedge clk);
    #1 chk("R3 no early expiry", {31'b0, irq}, 32'd0);
    @(posedge clk);
    #1 chk("R5 irq on expiry", {31'b0, irq}, 32'd1);
    chk("R5 no reset", {31'b0, sysRst}, 32'd0);
    repeat (2 * PER) @(posedge clk);
    #1 chk("R5 irq held", {30'b0, irq, sysRst}, 32'd2);

    // restart keys
    @(negedge clk);
    wr(M_KICK, 32'h0000_1970);
    chk("R4 bad restart ignored", {31'b0, irq}, 32'd1);
    wr(M_KICK, 32'h0000_1971);
    chk("R4 restart clears irq", {31'b0, irq}, 32'd0);
    repeat (5) @(negedge clk);
    wr(M_KICK, 32'h0000_1971);
    repeat (PER - 1) @(posedge clk);
    #1 chk("R4 restart postponed expiry", {31'b0, irq}, 32'd0);
    @(posedge clk);
    #1 chk("R3 expiry after restart", {31'b0, irq}, 32'd1);

    // restart in the expiry cycle
    @(negedge clk);
    wr(M_KICK, 32'h0000_1971);
    repeat (PER - 1) @(negedge clk);
    wr(M_KICK, 32'h0000_1971);
    chk("R12 restart beats expiry", {31'b0, irq}, 32'd0);
    repeat (PER - 1) @(posedge clk);
    #1 chk("R12 next period clean", {31'b0, irq}, 32'd0);
    @(posedge clk);
    #1 chk("R3 expiry one period later", {31'b0, irq}, 32'd1);

    // reset mode, external active low
    @(negedge clk);
    wr(M_MODE, 32'h2200_0000);
    wr(M_KICK, 32'h0000_1971);
    wr(M_MODE, 32'h2200_0005);
    repeat (PER - 1) @(posedge clk);
    #1 chk("R6 no early reset", {30'b0, sysRst, extRst}, 32'd1);
    @(posedge clk);
    #1 chk("R6 reset pulse start", {31'b0, sysRst}, 32'd1);
    chk("R9 active low pin", {31'b0, extRst}, 32'd0);
    chk("R6 irq clear", {31'b0, irq}, 32'd0);
    repeat (PLEN - 1) @(posedge clk);
    #1 chk("R6 pulse still high", {31'b0, sysRst}, 32'd1);
    @(posedge clk);
    #1 chk("R6 pulse length", {30'b0, sysRst, extRst}, 32'd1);
    rd(M_MODE, v); chk("R6 mode cleared", v, 32'h0);
    rd(M_STAT, v); chk("R6 status wdt bit", v, 32'h8000_0000);
    rd(M_IVAL, v); chk("R10 interval kept", v, 32'h0000_02BC);

    // external active high
    @(negedge clk);
    wr(M_MODE, 32'h2200_0007);
    chk("R9 idle low with pol 1", {31'b0, extRst}, 32'd0);
    repeat (PER) @(posedge clk);
    #1 chk("R9 active high pin", {30'b0, sysRst, extRst}, 32'd3);
    repeat (PLEN + 2) @(posedge clk);

    // dual mode, pin disabled
    @(negedge clk);
    wr(M_MODE, 32'h2200_0041);
    repeat (PER) @(posedge clk);
    #1 chk("R7 first expiry irq only", {30'b0, irq, sysRst}, 32'd2);
    repeat (PER - 1) @(posedge clk);
    #1 chk("R7 not yet reset", {31'b0, sysRst}, 32'd0);
    @(posedge clk);
    #1 chk("R7 second expiry resets", {30'b0, irq, sysRst}, 32'd1);
    chk("R9 pin disabled", {31'b0, extRst}, 32'd1);
    repeat (PLEN + 2) @(posedge clk);

    // software reset
    @(negedge clk);
    wr(M_SW, 32'h0000_1208);
    repeat (3) @(posedge clk);
    #1 chk("R8 bad key ignored", {31'b0, sysRst}, 32'd0);
    @(negedge clk);
    wr(M_SW, 32'h0000_1209);
    chk("R8 immediate reset", {31'b0, sysRst}, 32'd1);
    repeat (PLEN + 2) @(posedge clk);
    #1;
    rd(M_STAT, v); chk("R11 both bits sticky", v, 32'hC000_0000);
    rd(M_IVAL, v); chk("R10 kept over sw reset", v, 32'h0000_02BC);

    // power-on clears
    por();
    rd(M_STAT, v); chk("R11 cleared by power-on", v, 32'h0);
    rd(M_IVAL, v); chk("R10 power-on value", v, 32'h0000_07FF);

    // software reset in the expiry cycle
    @(negedge clk);
    wr(M_LEN, 32'h0000_0068);
    wr(M_MODE, 32'h2200_0001);
    repeat (PER - 1) @(negedge clk);
    wr(M_SW, 32'h0000_1209);
    chk("R12 reset pulse", {31'b0, sysRst}, 32'd1);
    rd(M_STAT, v); chk("R12 only sw bit", v, 32'h4000_0000);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule